// File: doc/BRIEF.md
# BCH Sector Error Fix-Up Engine

This block applies the corrections found by a BCH error locator to one 512-byte sector held in an attached byte-wide buffer. The locator supplies an error count, up to eight bit locations and a flag that marks the sector as beyond repair. Each location is counted from the end of a codeword made of the data followed by the ECC bits. Locations that fall in the ECC part are skipped. Every other location becomes a byte address and a one-hot bit mask. The engine reads the addressed byte, flips the masked bit and writes the byte back.

A single pulse on `start` captures the strength, the count, the locations and the flag. The engine then works through the locations in index order and raises `done` for one cycle when it has finished. `fail` reports a sector that was rejected. A separate combinational path reverses the byte order of a calculated syndrome for the selected strength, which is the order the locator expects to receive it in.

Top module: `bch_fixup`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done`, `fail`, `buf_rd` and `buf_wr` are 0 after that edge. While the engine is idle it never reads or writes the buffer.
- R2: `level` selects the strength. 0 means 4-bit correction with ECC bits 0..51, 1 means 8-bit with bits 0..103, 2 means 16-bit with bits 0..207, and 3 behaves like 1. A location at or below the last ECC bit causes no buffer access.
- R3: For a location above the ECC region, let d = loc − (last ECC bit + 1). The byte at address (4095 − d)/8 is XORed with 1 << (d mod 8).
- R4: A location whose d exceeds 4095 is skipped and causes no buffer access.
- R5: If `uncorr` is 1 when a start is accepted, no buffer access takes place. After that edge `done` is 1 for one cycle, `fail` is 1 and `busy` stays 0.
- R6: An error count above 8 is handled exactly like R5.
- R7: An error count of 0 causes no buffer access. After the start edge `done` pulses with `fail` = 0.
- R8: Only entries 0..count−1 are used, in ascending index order. Entry i occupies `err_locs[13*i +: 13]`.
- R9: An applied entry takes a read cycle followed by a write cycle to the same address. A skipped entry takes one cycle. `done` rises 2V+S+1 edges after the start edge, counting that edge, where V is the number of applied entries and S the number of skipped ones. `busy` is high in between, and `done` is a one-cycle pulse.
- R10: Two entries that address the same bit both take effect, so the bit ends unchanged.
- R11: `syn_out` byte i equals `syn_in` byte n−1−i for i < n, and is 0 for i ≥ n. n is 8, 13 or 28 for `level` 0, 1 or 2, and 13 for 3. Byte k sits at bits [8k +: 8]. The path is combinational.
- R12: A `start` that arrives while `busy` is high is ignored.
- R13: `fail` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sector; accepted only while idle |
| level | input | 2 | Correction strength select |
| err_cnt | input | 4 | Number of locations reported |
| err_locs | input | 104 | Eight 13-bit error locations, entry 0 in the low bits |
| uncorr | input | 1 | Locator declared the sector uncorrectable |
| busy | output | 1 | Engine is working through the locations |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last accepted sector was rejected |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd | output | 1 | Buffer read request; data is due one cycle later |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte to write |
| buf_rdata | input | 8 | Buffer read data, registered one cycle after `buf_rd` |
| syn_in | input | 224 | Calculated syndrome, byte 0 in the low bits |
| syn_out | output | 224 | Byte-reversed syndrome for the locator |

## Verification
The assertions rely on three properties of the environment. The attached buffer returns read data exactly one cycle after `buf_rd`. Nothing else writes the buffer while `busy` is high. The inputs that go with `start` are valid in the cycle `start` is sampled. The stimulus meets these conditions by modelling the buffer as a registered one-cycle memory that only the engine writes. It reloads the buffer contents only while the engine is idle, and it drives every input a half cycle before the edge that samples it. The one deliberate start during `busy` carries a rejected sector, so that if it were wrongly accepted the effect would show at the ports.

// File: rtl/bch_fix_pkg.sv
// Package: shared encodings and per-strength sizes for the BCH fix-up engine.
// Assumes callers pass the 2-bit strength select unchanged from the top port.
package bch_fix_pkg;

    typedef enum logic [1:0] {
        LVL_T4  = 2'd0,
        LVL_T8  = 2'd1,
        LVL_T16 = 2'd2,
        LVL_RSV = 2'd3
    } bch_level_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fix_state_e;

    // Number of ECC nibbles stored per sector for a strength; reserved acts as T8.
    function automatic int ecc_nibbles(input logic [1:0] lvl);
        case (lvl)
            LVL_T4:  return 13;
            LVL_T16: return 52;
            default: return 26;
        endcase
    endfunction

    // Number of ECC bits at the tail of the codeword.
    function automatic int ecc_bits(input logic [1:0] lvl);
        return ecc_nibbles(lvl) * 4;
    endfunction

    // Number of syndrome bytes handed to the locator for a strength.
    function automatic int syn_bytes(input logic [1:0] lvl);
        case (lvl)
            LVL_T4:  return 8;
            LVL_T16: return 28;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/bch_loc_map.sv
// Module: bch_loc_map
// Turns one codeword bit location into a buffer byte address and bit mask.
// Locations inside the ECC tail or past the data region set apply low.
// Assumes LOC_W is wide enough to hold the data bits plus the largest ECC tail.
module bch_loc_map
    import bch_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int LOC_W        = 13,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int DATA_BITS   = SECTOR_BYTES * 8
) (
    input  logic [1:0]        level,
    input  logic [LOC_W-1:0]  loc,
    output logic              apply,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        bit_mask
);

    logic [LOC_W:0] loc_x;
    logic [LOC_W:0] ecc_x;
    logic [LOC_W:0] d_x;
    logic [LOC_W:0] flip_x;

    // Offset past the ECC tail, mirror into the data region, derive address and mask.
    always_comb begin
        loc_x     = {1'b0, loc};
        ecc_x     = (LOC_W+1)'(ecc_bits(level));
        d_x       = loc_x - ecc_x;
        apply     = (loc_x >= ecc_x) && (d_x < (LOC_W+1)'(DATA_BITS));
        flip_x    = (LOC_W+1)'(DATA_BITS - 1) - d_x;
        byte_addr = ADDR_W'(flip_x >> 3);
        bit_mask  = 8'b1 << d_x[2:0];
    end

endmodule

// File: rtl/bch_syn_reverse.sv
// Module: bch_syn_reverse
// Reverses the byte order of the first n syndrome bytes, n set by the strength;
// bytes at or above n are driven to zero. Purely combinational.
// Assumes SYN_MAX is at least the largest syndrome length (28).
module bch_syn_reverse
    import bch_fix_pkg::*;
#(
    parameter int SYN_MAX = 28,
    localparam int IDX_W  = $clog2(SYN_MAX)
) (
    input  logic [1:0]           level,
    input  logic [SYN_MAX*8-1:0] syn_in,
    output logic [SYN_MAX*8-1:0] syn_out
);

    logic [7:0]     in_b [SYN_MAX];
    logic [IDX_W:0] n_bytes;

    // Active syndrome length for the selected strength.
    always_comb n_bytes = (IDX_W+1)'(syn_bytes(level));

    for (genvar i = 0; i < SYN_MAX; i++) begin : g_byte
        localparam logic [IDX_W:0] POS = (IDX_W+1)'(i);
        assign in_b[i] = syn_in[i*8 +: 8];
        assign syn_out[i*8 +: 8] = (POS < n_bytes) ? in_b[IDX_W'(n_bytes - POS - 1'b1)] : 8'h00;
    end

endmodule

// File: rtl/bch_fix_ctrl.sv
// Module: bch_fix_ctrl
// Sequencer: captures a sector's locator result on start, rejects bad sectors,
// and walks the locations in index order doing a read then write per applied
// entry. Assumes buffer read data arrives one cycle after buf_rd and that no
// other agent writes the buffer while busy is high.
module bch_fix_ctrl
    import bch_fix_pkg::*;
#(
    parameter int MAX_ERR = 8,
    parameter int CNT_W   = 4,
    parameter int LOC_W   = 13,
    parameter int ADDR_W  = 9,
    localparam int SEL_W  = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               level,
    input  logic [CNT_W-1:0]         err_cnt,
    input  logic [MAX_ERR*LOC_W-1:0] err_locs,
    input  logic                     uncorr,
    output logic [LOC_W-1:0]         cur_loc,
    output logic [1:0]               cur_level,
    input  logic                     map_apply,
    input  logic [ADDR_W-1:0]        map_addr,
    input  logic [7:0]               map_mask,
    output logic                     busy,
    output logic                     done,
    output logic                     fail,
    output logic                     buf_rd,
    output logic                     buf_wr,
    output logic [7:0]               buf_wdata,
    input  logic [7:0]               buf_rdata
);

    fix_state_e       state_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       lvl_q;
    logic [LOC_W-1:0] locs_q [MAX_ERR];
    logic             done_q;
    logic             fail_q;
    logic             reject;
    logic             last_entry;

    // Sector rejection test and last-entry detect.
    always_comb begin
        reject     = uncorr || (err_cnt > CNT_W'(MAX_ERR));
        last_entry = (idx_q + CNT_W'(1)) == cnt_q;
    end

    // Main sequencer: capture on start, then read/write or skip each entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            lvl_q   <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fail_q <= reject;
                        lvl_q  <= level;
                        cnt_q  <= err_cnt;
                        idx_q  <= '0;
                        for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= err_locs[k*LOC_W +: LOC_W];
                        if (reject || (err_cnt == '0)) done_q  <= 1'b1;
                        else                           state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (map_apply) begin
                        state_q <= ST_WRITE;
                    end else if (last_entry) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
                ST_WRITE: begin
                    if (last_entry) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q   <= idx_q + CNT_W'(1);
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode: current entry to the mapper, buffer strobes and write data.
    always_comb begin
        cur_loc   = locs_q[SEL_W'(idx_q)];
        cur_level = lvl_q;
        busy      = state_q != ST_IDLE;
        done      = done_q;
        fail      = fail_q;
        buf_rd    = (state_q == ST_READ) && map_apply;
        buf_wr    = state_q == ST_WRITE;
        buf_wdata = buf_rdata ^ map_mask;
    end

    // R9
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(buf_rd));

    // R9
    rmw_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> (map_addr == $past(map_addr)));

    // R5
    reject_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && uncorr) |=> (done && fail && !busy));

    // R6
    reject_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (err_cnt > CNT_W'(MAX_ERR))) |=> (done && fail && !busy));

    // R7
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !uncorr && (err_cnt == '0)) |=> (done && !fail && !busy));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!buf_rd && !buf_wr));

    // R13
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start || busy) |=> $stable(fail));

endmodule

// File: rtl/bch_fixup.sv
// Module: bch_fixup (top)
// BCH sector error fix-up: applies up to MAX_ERR locator results to an attached
// byte buffer by read-modify-write, and byte-reverses the calculated syndrome.
// Assumes a one-cycle-latency buffer that only this block writes while busy.
module bch_fixup
    import bch_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_ERR      = 8,
    parameter int CNT_W        = 4,
    parameter int LOC_W        = 13,
    parameter int SYN_MAX      = 28,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               level,
    input  logic [CNT_W-1:0]         err_cnt,
    input  logic [MAX_ERR*LOC_W-1:0] err_locs,
    input  logic                     uncorr,
    output logic                     busy,
    output logic                     done,
    output logic                     fail,
    output logic [ADDR_W-1:0]        buf_addr,
    output logic                     buf_rd,
    output logic                     buf_wr,
    output logic [7:0]               buf_wdata,
    input  logic [7:0]               buf_rdata,
    input  logic [SYN_MAX*8-1:0]     syn_in,
    output logic [SYN_MAX*8-1:0]     syn_out
);

    logic [LOC_W-1:0]  cur_loc;
    logic [1:0]        cur_level;
    logic              map_apply;
    logic [ADDR_W-1:0] map_addr;
    logic [7:0]        map_mask;

    bch_fix_ctrl #(
        .MAX_ERR (MAX_ERR),
        .CNT_W   (CNT_W),
        .LOC_W   (LOC_W),
        .ADDR_W  (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .level     (level),
        .err_cnt   (err_cnt),
        .err_locs  (err_locs),
        .uncorr    (uncorr),
        .cur_loc   (cur_loc),
        .cur_level (cur_level),
        .map_apply (map_apply),
        .map_addr  (map_addr),
        .map_mask  (map_mask),
        .busy      (busy),
        .done      (done),
        .fail      (fail),
        .buf_rd    (buf_rd),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .buf_rdata (buf_rdata)
    );

    bch_loc_map #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .LOC_W        (LOC_W)
    ) u_map (
        .level     (cur_level),
        .loc       (cur_loc),
        .apply     (map_apply),
        .byte_addr (map_addr),
        .bit_mask  (map_mask)
    );

    bch_syn_reverse #(
        .SYN_MAX (SYN_MAX)
    ) u_rev (
        .level   (level),
        .syn_in  (syn_in),
        .syn_out (syn_out)
    );

    // Buffer address comes straight from the mapper.
    assign buf_addr = map_addr;

endmodule

// File: tb/sim_bch_fixup.sv
`timescale 1ns/1ps
module sim_bch_fixup;

    localparam int NB    = 512;
    localparam int NE    = 8;
    localparam int LW    = 13;
    localparam int SB    = 28;
    localparam int NVEC  = 11;

    typedef struct packed {
        logic [3:0]     req;
        logic [1:0]     lvl;
        logic [3:0]     cnt;
        logic           unc;
        logic [NE*LW-1:0] locs;
    } vec_t;

    // Entries listed 7..0; entry 0 is rightmost.
    localparam vec_t VECS [NVEC] = '{
        // R3: first data bit maps to last byte, bit 0
        '{4'd3, 2'd1, 4'd1, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd104}},
        // R2: ECC-region entries skipped, last data bit maps to byte 0 bit 7
        '{4'd2, 2'd1, 4'd3, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd4199,13'd0,13'd103}},
        // R3: 4-bit strength offsets
        '{4'd3, 2'd0, 4'd2, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd60,13'd52}},
        // R3: 16-bit strength, full eight entries, one in ECC tail
        '{4'd3, 2'd2, 4'd8, 1'b0, {13'd207,13'd4303,13'd4000,13'd3000,13'd2000,13'd1000,13'd300,13'd208}},
        // R10: same bit twice cancels
        '{4'd10, 2'd1, 4'd2, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd500,13'd500}},
        // R5: uncorrectable flag
        '{4'd5, 2'd1, 4'd3, 1'b1, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd400,13'd300,13'd200}},
        // R6: count above eight
        '{4'd6, 2'd1, 4'd9, 1'b0, {13'd900,13'd800,13'd700,13'd600,13'd500,13'd400,13'd300,13'd200}},
        // R7: zero count
        '{4'd7, 2'd2, 4'd0, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd300}},
        // R2: reserved level acts as 8-bit strength
        '{4'd2, 2'd3, 4'd2, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd104,13'd103}},
        // R4: location past the data region skipped
        '{4'd4, 2'd0, 4'd2, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd53,13'd4148}},
        // R8: entries beyond the count ignored
        '{4'd8, 2'd1, 4'd2, 1'b0, {13'd1500,13'd1400,13'd1300,13'd1200,13'd1100,13'd1000,13'd300,13'd200}}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        level = '0;
    logic [3:0]        err_cnt = '0;
    logic [NE*LW-1:0]  err_locs = '0;
    logic              uncorr = 1'b0;
    logic              busy, done, fail;
    logic [8:0]        buf_addr;
    logic              buf_rd, buf_wr;
    logic [7:0]        buf_wdata;
    logic [7:0]        buf_rdata = '0;
    logic [SB*8-1:0]   syn_in = '0;
    logic [SB*8-1:0]   syn_out;

    logic [7:0] mem [NB];
    logic [7:0] expm [NB];
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bch_fixup u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .level(level), .err_cnt(err_cnt),
        .err_locs(err_locs), .uncorr(uncorr), .busy(busy), .done(done), .fail(fail),
        .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .syn_in(syn_in), .syn_out(syn_out)
    );

    // One-cycle-latency buffer model.
    always @(posedge clk) begin
        if (buf_wr) mem[buf_addr] <= buf_wdata;
        if (buf_rd) buf_rdata <= mem[buf_addr];
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int tail_bits(input logic [1:0] l);
        if (l == 2'd0) return 52;
        if (l == 2'd2) return 208;
        return 104;
    endfunction

    task automatic run_vec(input int req, input logic [1:0] l, input logic [3:0] c, input logic u,
                           input logic [NE*LW-1:0] ls, input int seed, input bit poke);
        int v = 0, s = 0, lat, mism, exp_lat;
        bit exp_fail;
        string rq;
        rq = $sformatf("R%0d", req);
        @(negedge clk);
        for (int i = 0; i < NB; i++) begin
            mem[i]  = 8'(i * 13 + seed * 29 + 5);
            expm[i] = mem[i];
        end
        exp_fail = u || (c > 4'd8);
        if (!exp_fail) begin
            for (int i = 0; i < int'(c); i++) begin
                int loc, d;
                loc = int'(ls[i*LW +: LW]);
                d = loc - tail_bits(l);
                if (d >= 0 && d < 4096) begin
                    v++;
                    expm[(4095 - d) / 8] = expm[(4095 - d) / 8] ^ 8'(1 << (d % 8));
                end else begin
                    s++;
                end
            end
        end
        exp_lat = (exp_fail || c == 0) ? 1 : 2 * v + s + 1;
        level = l; err_cnt = c; uncorr = u; err_locs = ls; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy == (exp_lat > 1), "R9", {rq, " busy after start"}, int'(busy), int'(exp_lat > 1));
        if (poke) begin
            // R12: rejected-sector start while busy must be ignored
            start = 1'b1; uncorr = 1'b1; err_cnt = 4'd9; level = 2'd0;
        end
        while (!done && lat < 4000) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
        end
        uncorr = 1'b0;
        chk(lat == exp_lat, "R9", {rq, " done latency"}, lat, exp_lat);
        chk(fail == exp_fail, rq, "fail flag", int'(fail), int'(exp_fail));
        @(negedge clk);
        chk(!done, "R9", {rq, " done pulse width"}, int'(done), 0);
        repeat (3) @(negedge clk);
        // R13: fail held while idle
        chk(fail == exp_fail, "R13", {rq, " fail held"}, int'(fail), int'(exp_fail));
        mism = 0;
        for (int i = 0; i < NB; i++) if (mem[i] !== expm[i]) mism++;
        chk(mism == 0, rq, "mismatching buffer bytes", mism, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !fail && !buf_rd && !buf_wr, "R1", "outputs in reset",
            int'({busy, done, fail, buf_rd, buf_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail, "R1", "outputs after reset", int'({busy, done, fail}), 0);

        // Table walk
        for (int k = 0; k < NVEC; k++)
            run_vec(int'(VECS[k].req), VECS[k].lvl, VECS[k].cnt, VECS[k].unc, VECS[k].locs, k, 1'b0);

        // R12: start while busy ignored
        run_vec(12, 2'd1, 4'd2, 1'b0, {13'd0,13'd0,13'd0,13'd0,13'd0,13'd0,13'd112,13'd104}, 20, 1'b1);

        // R11: syndrome reversal for each level
        for (int l = 0; l < 4; l++) begin
            int n, bad;
            logic [7:0] e;
            n = (l == 0) ? 8 : (l == 2) ? 28 : 13;
            @(negedge clk);
            level = 2'(l);
            for (int i = 0; i < SB; i++) syn_in[i*8 +: 8] = 8'(8'h10 + i + 3 * l);
            #1;
            bad = 0;
            for (int i = 0; i < SB; i++) begin
                e = (i < n) ? syn_in[(n-1-i)*8 +: 8] : 8'h00;
                if (syn_out[i*8 +: 8] !== e) bad++;
            end
            chk(bad == 0, "R11", $sformatf("reversed bytes wrong, level %0d", l), bad, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule